// File: doc/BRIEF.md
# Sorted Candidate Neighbour Queue

This block holds the best k candidate neighbours of one spatial query in a register bank that is kept in ascending distance order. Each slot stores a distance, a point pointer and an empty flag. A search engine offers at most one candidate per clock. Every slot compares the candidate with its own distance in parallel, so the candidate lands in its sorted place in one cycle. Worse entries move down one slot, and the entry in the last active slot falls out.

A query starts with an init pulse. The pulse loads every slot with a placeholder at the query radius and sets the active length k. A plain k-nearest search uses the all-ones radius. A radius below that turns the queue into a bounded ball query, because only candidates strictly closer than the radius can enter. The largest active distance is presented continuously so that the tree walker can prune half-spaces. At the end of the query the sorted contents are read out one index at a time, and placeholder slots are marked as empty.

Top module: `sorted_nbr_queue`

## Requirements
- R1: Slots 0 to k-1 are always in non-decreasing distance order, with slot 0 the closest. A candidate whose distance equals existing entries is placed after all of them.
- R2: A candidate offered with `cand_valid` in one cycle is in its sorted slot after the next rising clock edge. A new candidate may be offered every cycle.
- R3: A candidate is accepted only when its distance is strictly below `top_dist`. A candidate at or above `top_dist` leaves every slot and every output unchanged.
- R4: When a candidate is accepted, the entries farther than it move down one slot and the former entry in slot k-1 is discarded.
- R5: `top_dist` is a registered output. It always equals the distance held in slot k-1, and it shows the effect of a clock edge right after that edge.
- R6: `init_valid` loads every slot with distance `init_dist`, pointer 0 and the empty flag set, and loads k from `init_len`. When `init_valid` and `cand_valid` are high in the same cycle, the init wins and the candidate is dropped.
- R7: k is set at init to a value from 1 to DEPTH. Slots at index k or above take no part in insertion and do not affect `top_dist`.
- R8: `rd_idx` picks a slot, and `rd_dist`, `rd_ptr` and `rd_empty` show that slot's content one clock later. `rd_empty` is 1 for a placeholder and 0 for a captured candidate. An index at or above k returns `rd_empty`=1, an all-ones distance and pointer 0.
- R9: Synchronous reset sets k to DEPTH and fills every slot with an all-ones distance, pointer 0 and the empty flag. After reset `top_dist` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid | input | 1 | Start a query: load placeholders and length |
| init_dist | input | DIST_W | Placeholder distance (query radius) |
| init_len | input | $clog2(DEPTH+1) | Active length k, from 1 to DEPTH |
| cand_valid | input | 1 | Candidate present this cycle |
| cand_dist | input | DIST_W | Candidate distance |
| cand_ptr | input | PTR_W | Candidate point pointer |
| top_dist | output | DIST_W | Largest active distance, registered |
| rd_idx | input | $clog2(DEPTH) | Slot index to read |
| rd_dist | output | DIST_W | Distance of the selected slot, registered |
| rd_ptr | output | PTR_W | Pointer of the selected slot, registered |
| rd_empty | output | 1 | Selected slot holds a placeholder or lies beyond k |

## Verification
The assertions assume that `init_len` lies between 1 and DEPTH whenever `init_valid` is high. They also assume that distances are unsigned and that the slot order only has to hold for indices below the current k. The stimulus keeps every init length within 1 to DEPTH. It uses the all-ones radius and smaller radii, offers candidates whose distance equals, exceeds or falls below `top_dist`, includes runs of equal distances, and raises init and candidate together once. The read index sweeps every slot continuously, so slots beyond k are read as well.

// File: rtl/snq_pkg.sv
package snq_pkg;
  // Per-slot decision for the next cycle
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_SHIFT = 2'd1,
    SLOT_TAKE  = 2'd2
  } slot_act_e;
endpackage

// File: rtl/snq_slot.sv
module snq_slot
  import snq_pkg::*;
#(
  parameter int DIST_W = 16,
  parameter int PTR_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic [DIST_W-1:0] init_dist_i,
  input  logic              en_i,
  input  logic [DIST_W-1:0] cand_dist_i,
  input  logic [PTR_W-1:0]  cand_ptr_i,
  input  logic              gt_up_i,
  input  logic [DIST_W-1:0] up_dist_i,
  input  logic [PTR_W-1:0]  up_ptr_i,
  input  logic              up_empty_i,
  output logic              gt_o,
  output logic [DIST_W-1:0] dist_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              empty_o,
  output logic [DIST_W-1:0] nxt_dist_o
);
  logic [DIST_W-1:0] dist_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              empty_q;
  logic [PTR_W-1:0]  nxt_ptr;
  logic              nxt_empty;
  slot_act_e         act;

  // strict compare: ties leave the older entry in front
  assign gt_o = dist_q > cand_dist_i;

  always_comb begin
    if (!en_i || !gt_o)  act = SLOT_HOLD;
    else if (!gt_up_i)   act = SLOT_TAKE;
    else                 act = SLOT_SHIFT;
  end

  always_comb begin
    unique case (act)
      SLOT_TAKE: begin
        nxt_dist_o = cand_dist_i;
        nxt_ptr    = cand_ptr_i;
        nxt_empty  = 1'b0;
      end
      SLOT_SHIFT: begin
        nxt_dist_o = up_dist_i;
        nxt_ptr    = up_ptr_i;
        nxt_empty  = up_empty_i;
      end
      default: begin
        nxt_dist_o = dist_q;
        nxt_ptr    = ptr_q;
        nxt_empty  = empty_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_q  <= '1;
      ptr_q   <= '0;
      empty_q <= 1'b1;
    end else if (init_i) begin
      dist_q  <= init_dist_i;
      ptr_q   <= '0;
      empty_q <= 1'b1;
    end else begin
      dist_q  <= nxt_dist_o;
      ptr_q   <= nxt_ptr;
      empty_q <= nxt_empty;
    end
  end

  assign dist_o  = dist_q;
  assign ptr_o   = ptr_q;
  assign empty_o = empty_q;

  // R2: a captured candidate is never a placeholder afterwards
  assert_take_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (act == SLOT_TAKE && !init_i) |=> (!empty_o && dist_o == $past(cand_dist_i)));
endmodule

// File: rtl/snq_readout.sv
module snq_readout #(
  parameter int DEPTH  = 32,
  parameter int DIST_W = 16,
  parameter int PTR_W  = 10,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DIST_W-1:0] dist_i  [DEPTH],
  input  logic [PTR_W-1:0]  ptr_i   [DEPTH],
  input  logic              empty_i [DEPTH],
  output logic [DIST_W-1:0] rd_dist_o,
  output logic [PTR_W-1:0]  rd_ptr_o,
  output logic              rd_empty_o
);
  logic in_range;
  assign in_range = LEN_W'(rd_idx_i) < len_i;

  always_ff @(posedge clk) begin
    if (rst || !in_range) begin
      rd_dist_o  <= '1;
      rd_ptr_o   <= '0;
      rd_empty_o <= 1'b1;
    end else begin
      rd_dist_o  <= dist_i[rd_idx_i];
      rd_ptr_o   <= ptr_i[rd_idx_i];
      rd_empty_o <= empty_i[rd_idx_i];
    end
  end

  // R8: slots past the active length always read as empty
  assert_beyond_len_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !in_range |=> (rd_empty_o && rd_ptr_o == '0));
endmodule

// File: rtl/sorted_nbr_queue.sv
module sorted_nbr_queue #(
  parameter int DEPTH  = 32,
  parameter int DIST_W = 16,
  parameter int PTR_W  = 10,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_valid,
  input  logic [DIST_W-1:0] init_dist,
  input  logic [LEN_W-1:0]  init_len,
  input  logic              cand_valid,
  input  logic [DIST_W-1:0] cand_dist,
  input  logic [PTR_W-1:0]  cand_ptr,
  output logic [DIST_W-1:0] top_dist,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DIST_W-1:0] rd_dist,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              rd_empty
);
  logic [LEN_W-1:0]  len_q;
  logic [DIST_W-1:0] top_q;
  logic              accept;
  logic              gt       [DEPTH];
  logic [DIST_W-1:0] dist_w   [DEPTH];
  logic [PTR_W-1:0]  ptr_w    [DEPTH];
  logic              empty_w  [DEPTH];
  logic [DIST_W-1:0] nxt_dist [DEPTH];

  assign accept = cand_valid && !init_valid && (cand_dist < top_q);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              en;
    logic              gt_up;
    logic [DIST_W-1:0] up_dist;
    logic [PTR_W-1:0]  up_ptr;
    logic              up_empty;

    assign en = accept && (LEN_W'(i) < len_q);

    if (i == 0) begin : g_head
      assign gt_up    = 1'b0;
      assign up_dist  = cand_dist;
      assign up_ptr   = cand_ptr;
      assign up_empty = 1'b0;
    end else begin : g_body
      assign gt_up    = gt[i-1];
      assign up_dist  = dist_w[i-1];
      assign up_ptr   = ptr_w[i-1];
      assign up_empty = empty_w[i-1];
    end

    snq_slot #(.DIST_W(DIST_W), .PTR_W(PTR_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .init_i     (init_valid),
      .init_dist_i(init_dist),
      .en_i       (en),
      .cand_dist_i(cand_dist),
      .cand_ptr_i (cand_ptr),
      .gt_up_i    (gt_up),
      .up_dist_i  (up_dist),
      .up_ptr_i   (up_ptr),
      .up_empty_i (up_empty),
      .gt_o       (gt[i]),
      .dist_o     (dist_w[i]),
      .ptr_o      (ptr_w[i]),
      .empty_o    (empty_w[i]),
      .nxt_dist_o (nxt_dist[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_W'(DEPTH);
      top_q <= '1;
    end else if (init_valid) begin
      len_q <= init_len;
      top_q <= init_dist;
    end else if (accept) begin
      top_q <= nxt_dist[IDX_W'(len_q - 1'b1)];
    end
  end

  assign top_dist = top_q;

  snq_readout #(.DEPTH(DEPTH), .DIST_W(DIST_W), .PTR_W(PTR_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_idx_i  (rd_idx),
    .len_i     (len_q),
    .dist_i    (dist_w),
    .ptr_i     (ptr_w),
    .empty_i   (empty_w),
    .rd_dist_o (rd_dist),
    .rd_ptr_o  (rd_ptr),
    .rd_empty_o(rd_empty)
  );

  // Input assumption: an init carries a legal length (R7)
  assert_len_legal_R7: assert property (@(posedge clk) disable iff (rst)
    init_valid |-> (init_len != '0 && init_len <= LEN_W'(DEPTH)));

  // R5: the registered maximum tracks the last active slot
  assert_top_is_last_R5: assert property (@(posedge clk) disable iff (rst)
    top_q == dist_w[IDX_W'(len_q - 1'b1)]);

  // R3: a candidate not closer than the maximum changes nothing
  assert_reject_keeps_top_R3: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !init_valid && cand_dist >= top_q) |=> $stable(top_q));

  // R4: an accepted candidate never raises the maximum
  assert_accept_lowers_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> top_q <= $past(top_q));

  // R6: init loads the radius as the maximum
  assert_init_radius_R6: assert property (@(posedge clk) disable iff (rst)
    init_valid |=> top_q == $past(init_dist));

  // R1: active slots stay in ascending order
  for (genvar j = 0; j < DEPTH - 1; j++) begin : g_order
    assert_sorted_R1: assert property (@(posedge clk) disable iff (rst)
      (LEN_W'(j + 1) < len_q) |-> dist_w[j] <= dist_w[j+1]);
  end
endmodule

// File: tb/sim_sorted_nbr_queue.sv
module sim_sorted_nbr_queue;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 32;
  localparam int DIST_W = 16;
  localparam int PTR_W  = 10;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LEN_W  = $clog2(DEPTH + 1);
  localparam int ONES   = (1 << DIST_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_valid = 1'b0;
  logic [DIST_W-1:0] init_dist = '0;
  logic [LEN_W-1:0]  init_len = '0;
  logic cand_valid = 1'b0;
  logic [DIST_W-1:0] cand_dist = '0;
  logic [PTR_W-1:0]  cand_ptr = '0;
  logic [DIST_W-1:0] top_dist;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [DIST_W-1:0] rd_dist;
  logic [PTR_W-1:0]  rd_ptr;
  logic              rd_empty;

  always #(CLK_P/2) clk = ~clk;

  sorted_nbr_queue #(.DEPTH(DEPTH), .DIST_W(DIST_W), .PTR_W(PTR_W)) u0 (
    .clk(clk), .rst(rst), .init_valid(init_valid), .init_dist(init_dist),
    .init_len(init_len), .cand_valid(cand_valid), .cand_dist(cand_dist),
    .cand_ptr(cand_ptr), .top_dist(top_dist), .rd_idx(rd_idx),
    .rd_dist(rd_dist), .rd_ptr(rd_ptr), .rd_empty(rd_empty)
  );

  // Behavioural reference
  int m_d [DEPTH];
  int m_p [DEPTH];
  bit m_e [DEPTH];
  int m_k;
  int e_top, e_rd_d, e_rd_p;
  bit e_rd_e;

  int n_chk = 0, n_err = 0;
  bit chk_on = 1'b0;
  string cur_tag = "R9";

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin m_d[i] = ONES; m_p[i] = 0; m_e[i] = 1; end
      m_k = DEPTH;
      e_rd_d = ONES; e_rd_p = 0; e_rd_e = 1;
    end else begin
      if (int'(rd_idx) < m_k) begin
        e_rd_d = m_d[rd_idx]; e_rd_p = m_p[rd_idx]; e_rd_e = m_e[rd_idx];
      end else begin
        e_rd_d = ONES; e_rd_p = 0; e_rd_e = 1;
      end
      if (init_valid) begin
        for (int i = 0; i < DEPTH; i++) begin m_d[i] = int'(init_dist); m_p[i] = 0; m_e[i] = 1; end
        m_k = int'(init_len);
      end else if (cand_valid && int'(cand_dist) < m_d[m_k-1]) begin
        int pos;
        pos = m_k - 1;
        for (int j = m_k - 1; j >= 0; j--) if (m_d[j] > int'(cand_dist)) pos = j;
        for (int j = m_k - 1; j > pos; j--) begin
          m_d[j] = m_d[j-1]; m_p[j] = m_p[j-1]; m_e[j] = m_e[j-1];
        end
        m_d[pos] = int'(cand_dist); m_p[pos] = int'(cand_ptr); m_e[pos] = 0;
      end
    end
    e_top = m_d[m_k-1];
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check(int'(top_dist) == e_top, "R5", "top_dist", int'(top_dist), e_top);
      check(int'(rd_dist) == e_rd_d, cur_tag, "rd_dist", int'(rd_dist), e_rd_d);
      check(int'(rd_ptr) == e_rd_p, cur_tag, "rd_ptr", int'(rd_ptr), e_rd_p);
      check(rd_empty == e_rd_e, cur_tag, "rd_empty", int'(rd_empty), int'(e_rd_e));
    end
    rd_idx <= rd_idx + 1'b1;
  end

  task automatic idle(input int n);
    cand_valid = 0; init_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input int r, input int k);
    init_valid = 1; init_dist = DIST_W'(r); init_len = LEN_W'(k); cand_valid = 0;
    @(negedge clk);
    init_valid = 0;
  endtask

  task automatic offer(input int d, input int p);
    cand_valid = 1; cand_dist = DIST_W'(d); cand_ptr = PTR_W'(p);
    @(negedge clk);
    cand_valid = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk_on = 1;
    cur_tag = "R9";                        // reset contents
    idle(3);
    rst = 0;
    idle(34);

    cur_tag = "R6";                        // radius placeholders, k=8
    start(500, 8);
    idle(34);

    cur_tag = "R2";                        // one candidate per cycle
    for (int i = 0; i < 24; i++) offer($urandom_range(0, 999), i + 1);
    idle(34);

    cur_tag = "R1";                        // equal distances keep arrival order
    start(1000, 6);
    offer(100, 11); offer(100, 12); offer(50, 13); offer(100, 14);
    offer(100, 15); offer(100, 16); offer(20, 17);
    idle(34);

    cur_tag = "R3";                        // at-top and above-top are dropped
    offer(100, 21); offer(900, 22); offer(65535, 23); offer(99, 24);
    start(0, 4);
    offer(0, 25); offer(5, 26);
    idle(34);

    cur_tag = "R4";                        // full length overflow
    start(ONES, DEPTH);
    for (int i = 0; i < 70; i++) offer($urandom_range(0, 3000), 100 + i);
    idle(34);

    cur_tag = "R7";                        // short lengths
    start(ONES, 1);
    offer(40, 201); offer(60, 202); offer(10, 203); offer(10, 204);
    idle(34);
    start(300, 3);
    for (int i = 0; i < 10; i++) offer($urandom_range(0, 400), 210 + i);
    idle(34);

    cur_tag = "R6";                        // init beats a same-cycle candidate
    init_valid = 1; init_dist = 700; init_len = 5;
    cand_valid = 1; cand_dist = 3; cand_ptr = 250;
    @(negedge clk);
    idle(34);

    cur_tag = "R8";                        // mixed fill then full sweep
    start(2000, 20);
    for (int i = 0; i < 12; i++) offer($urandom_range(0, 2500), 300 + i);
    idle(40);

    cur_tag = "R2";                        // back-to-back stream with inits between
    for (int q = 0; q < 4; q++) begin
      start($urandom_range(100, 5000), $urandom_range(1, DEPTH));
      for (int i = 0; i < 40; i++) offer($urandom_range(0, 5000), 400 + i);
      idle(34);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule